// File: doc/BRIEF.md
# Alarm and Watchdog Supervisor

This block sits beside a real-time clock and watches it for two kinds of event. The alarm compares the current seconds, minutes, hours and date against four programmed match values, and each field can be left out of the comparison. The watchdog counts a 32 Hz tick that only advances while the oscillator runs. If software does not kick it within a stored timeout, it raises an event. Two further event inputs come from an external supply monitor: the supply falling below its warning level, and the switchover to the backup supply.

Each of the four events sets a sticky flag. Each flag has its own enable bit, and the enable bits gate the flags onto one shared active-low interrupt pin. Software reaches the block through a small synchronous register port. Reading the flags register returns all flags and clears them. The watchdog timeout register models a non-volatile value. The counter takes its period from that register only at power-up reset and at each kick.

Top module: `sysmon_supervisor`

## Requirements
- R1: After reset the flags are 0, `irq_n` is 1, the control register reads 0x00, the match registers read 0, and the timeout register reads the `WD_INIT` parameter (default 10).
- R2: On a cycle with `sec_tick` high, the alarm flag (flags bit 0) is set in that clock edge if every unmasked field is equal to its match value. The fields are second = address 0, minute = 1, hour = 2, date = 3, with the value in bits 6:0. A difference in any unmasked field leaves the flag clear.
- R3: When bit 7 of a match register is 1, that field is left out of the comparison. When all four mask bits are 1, every `sec_tick` sets the alarm flag.
- R4: The alarm is evaluated only on cycles with `sec_tick` high. A matching time presented without `sec_tick` does not set the flag.
- R5: A read of address 6 returns the flags in bits 3:0 and clears them at that clock edge. An event that arrives in the same cycle as the read stays set.
- R6: While `osc_en` is 1 and the loaded timeout T is nonzero, each `wd_tick` advances the watchdog. On the T-th tick after the last load, the watchdog flag (flags bit 1) is set and the count restarts from zero.
- R7: Writing address 5 with bit 0 = 1 (kick) restarts the count and loads the timeout from address 4. A kick never sets the watchdog flag, even when it coincides with the expiring tick.
- R8: Writing address 4 alone does not change the running period. The new value takes effect only at the next kick.
- R9: With `osc_en` at 0, `wd_tick` has no effect on the count. A loaded timeout of 0 disables the watchdog.
- R10: A rising edge of `low_volt` sets flags bit 2, and a rising edge of `on_backup` sets flags bit 3. A level that stays high does not set a flag again after it has been cleared.
- R11: `irq_n` is 0 exactly when some flag is set together with its enable bit. The enable bits are at address 5: bit 4 alarm, bit 5 watchdog, bit 6 low voltage, bit 7 backup.
- R12: The match and timeout registers read back what was written. The control register reads back its enable bits with bits 3:0 as 0. Address 7 reads 0. `reg_rdata` is 0 when `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sec_tick | input | 1 | One-cycle strobe when the time fields hold a new second |
| cur_sec | input | DW-1 | Current seconds |
| cur_min | input | DW-1 | Current minutes |
| cur_hour | input | DW-1 | Current hours |
| cur_date | input | DW-1 | Current date |
| wd_tick | input | 1 | One-cycle 32 Hz strobe for the watchdog |
| osc_en | input | 1 | Oscillator running |
| low_volt | input | 1 | Supply below warning threshold |
| on_backup | input | 1 | Running from the backup supply |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid in the cycle of `reg_rd` |
| irq_n | output | 1 | Shared active-low interrupt |
| flags | output | 4 | Pending flags: alarm, watchdog, low voltage, backup |

## Verification
Internal state shows up at the pins quickly, so a wrong value is caught early. A wrong match or mask bit changes the `flags` bit 0 at the next `sec_tick` edge. A wrong watchdog count or loaded period moves the cycle at which `flags` bit 1 rises, and the bench checks that bit tick by tick, on both sides of the expected expiry. A flag that fails to clear, or an enable bit that is wrong, shows up on `irq_n` in the cycle after the read or the control write. A read of the control or timeout register exposes a wrong enable or stored value at once.

// File: rtl/sysmon_pkg.sv
package sysmon_pkg;
  localparam int ADDR_W      = 3;
  localparam int NFIELD      = 4;
  localparam int NSRC        = 4;
  localparam logic [ADDR_W-1:0] RA_TIMEOUT = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CTRL    = 3'd5;
  localparam logic [ADDR_W-1:0] RA_FLAGS   = 3'd6;
  localparam int CTRL_KICK   = 0;
  localparam int CTRL_EN_LSB = 4;
  localparam int SRC_ALARM   = 0;
  localparam int SRC_WDOG    = 1;
  localparam int SRC_LOWV    = 2;
  localparam int SRC_BKUP    = 3;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/sysmon_regs.sv
module sysmon_regs
  import sysmon_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] WD_INIT = DW'(10)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DW-1:0]              wdata,
  input  src_vec_t                   flags_in,
  output logic [DW-1:0]              rdata,
  output logic [NFIELD-1:0][DW-2:0]  alm_val,
  output logic [NFIELD-1:0]          alm_mask,
  output logic [DW-1:0]              wd_timeout,
  output src_vec_t                   src_en,
  output logic                       kick,
  output logic                       flags_clr
);
  localparam int VW = DW - 1;

  logic [NFIELD-1:0][DW-1:0] match_q;
  logic [NFIELD-1:0]         match_we;
  logic [DW-1:0]             tmo_q, tmo_d;
  src_vec_t                  en_q, en_d;
  logic                      ctrl_we, tmo_we;
  logic [DW-1:0]             rd_mux;

  assign ctrl_we   = wr && (addr == RA_CTRL);
  assign tmo_we    = wr && (addr == RA_TIMEOUT);
  assign kick      = ctrl_we && wdata[CTRL_KICK];
  assign flags_clr = rd && (addr == RA_FLAGS);

  for (genvar f = 0; f < NFIELD; f++) begin : g_match
    assign match_we[f] = wr && (addr == ADDR_W'(f));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           match_q[f] <= '0;
      else if (match_we[f]) match_q[f] <= wdata;
    end
    assign alm_val[f]  = match_q[f][VW-1:0];
    assign alm_mask[f] = match_q[f][DW-1];
  end

  always_comb begin
    tmo_d = tmo_q;
    en_d  = en_q;
    if (tmo_we)  tmo_d = wdata;
    if (ctrl_we) en_d  = wdata[CTRL_EN_LSB +: NSRC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q <= WD_INIT;
      en_q  <= '0;
    end else begin
      tmo_q <= tmo_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr < ADDR_W'(NFIELD)) begin
      rd_mux = match_q[addr[1:0]];
    end else if (addr == RA_TIMEOUT) begin
      rd_mux = tmo_q;
    end else if (addr == RA_CTRL) begin
      rd_mux[CTRL_EN_LSB +: NSRC] = en_q;
    end else if (addr == RA_FLAGS) begin
      rd_mux[NSRC-1:0] = flags_in;
    end
  end

  assign rdata      = rd ? rd_mux : '0;
  assign wd_timeout = tmo_q;
  assign src_en     = en_q;
endmodule

// File: rtl/sysmon_alarm.sv
module sysmon_alarm
  import sysmon_pkg::*;
#(
  parameter int VW = 7
) (
  input  logic                      sec_tick,
  input  logic [NFIELD-1:0][VW-1:0] cur,
  input  logic [NFIELD-1:0][VW-1:0] val,
  input  logic [NFIELD-1:0]         mask,
  output logic                      hit
);
  logic [NFIELD-1:0] field_ok;

  for (genvar f = 0; f < NFIELD; f++) begin : g_cmp
    assign field_ok[f] = mask[f] || (cur[f] == val[f]);
  end

  assign hit = sec_tick && (&field_ok);
endmodule

// File: rtl/sysmon_wdog.sv
module sysmon_wdog #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = W'(10)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         osc_en,
  input  logic         kick,
  input  logic [W-1:0] timeout,
  output logic         expire,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] reload_q, reload_d;
  logic [W-1:0] cnt_inc;
  logic         advance;

  assign cnt_inc = cnt_q + 1'b1;
  assign advance = tick && osc_en && (reload_q != '0);

  always_comb begin
    cnt_d    = cnt_q;
    reload_d = reload_q;
    expire   = 1'b0;
    if (kick) begin
      cnt_d    = '0;
      reload_d = timeout;
    end else if (advance) begin
      if (cnt_inc == reload_q) begin
        expire = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= INIT;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sysmon_supervisor.sv
module sysmon_supervisor
  import sysmon_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] WD_INIT = DW'(10)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [DW-2:0]     cur_sec,
  input  logic [DW-2:0]     cur_min,
  input  logic [DW-2:0]     cur_hour,
  input  logic [DW-2:0]     cur_date,
  input  logic              wd_tick,
  input  logic              osc_en,
  input  logic              low_volt,
  input  logic              on_backup,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_n,
  output logic [NSRC-1:0]   flags
);
  localparam int VW = DW - 1;

  logic [NFIELD-1:0][VW-1:0] cur_vec;
  logic [NFIELD-1:0][VW-1:0] alm_val;
  logic [NFIELD-1:0]         alm_mask;
  logic [DW-1:0]             wd_timeout;
  logic [DW-1:0]             wd_cnt;
  src_vec_t                  src_en, events, flags_q, flags_d;
  logic                      kick, flags_clr, alarm_hit, wd_expire;
  logic                      lv_q, bk_q;

  assign cur_vec = {cur_date, cur_hour, cur_min, cur_sec};

  sysmon_regs #(.DW(DW), .WD_INIT(WD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .flags_in(flags_q), .rdata(reg_rdata),
    .alm_val(alm_val), .alm_mask(alm_mask), .wd_timeout(wd_timeout),
    .src_en(src_en), .kick(kick), .flags_clr(flags_clr)
  );

  sysmon_alarm #(.VW(VW)) u_alarm (
    .sec_tick(sec_tick), .cur(cur_vec), .val(alm_val), .mask(alm_mask),
    .hit(alarm_hit)
  );

  sysmon_wdog #(.W(DW), .INIT(WD_INIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick(wd_tick), .osc_en(osc_en), .kick(kick),
    .timeout(wd_timeout), .expire(wd_expire), .cnt(wd_cnt)
  );

  always_comb begin
    events            = '0;
    events[SRC_ALARM] = alarm_hit;
    events[SRC_WDOG]  = wd_expire;
    events[SRC_LOWV]  = low_volt && !lv_q;
    events[SRC_BKUP]  = on_backup && !bk_q;
    flags_d = (flags_clr ? '0 : flags_q) | events;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      lv_q    <= 1'b0;
      bk_q    <= 1'b0;
    end else begin
      flags_q <= flags_d;
      lv_q    <= low_volt;
      bk_q    <= on_backup;
    end
  end

  assign irq_n = ~|(flags_q & src_en);
  assign flags = flags_q;
endmodule

// File: rtl/sysmon_supervisor_chk.sv
module sysmon_supervisor_chk
  import sysmon_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              wd_tick,
  input logic              osc_en,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              kick_bit,
  input logic              irq_n,
  input logic [NSRC-1:0]   flags,
  input logic [DW-1:0]     wd_cnt
);
  logic kick_w, rd_flags;
  assign kick_w   = reg_wr && (reg_addr == RA_CTRL) && kick_bit;
  assign rd_flags = reg_rd && (reg_addr == RA_FLAGS);

  assert_alarm_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[SRC_ALARM]) |-> $past(sec_tick));

  assert_read_clears_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !sec_tick) |=> !flags[SRC_ALARM]);

  assert_read_clears_wdog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !(wd_tick && osc_en)) |=> !flags[SRC_WDOG]);

  assert_wdog_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[SRC_WDOG]) |-> $past(wd_tick && osc_en));

  assert_kick_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_w && !flags[SRC_WDOG]) |=> !flags[SRC_WDOG]);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !kick_w) |=> $stable(wd_cnt));

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flags != '0));
endmodule

bind sysmon_supervisor sysmon_supervisor_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wd_tick(wd_tick),
  .osc_en(osc_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .kick_bit(reg_wdata[0]), .irq_n(irq_n), .flags(flags), .wd_cnt(wd_cnt)
);

// File: tb/tb_sysmon_supervisor.sv
`timescale 1ns/1ps
module tb_sysmon_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0, wd_tick = 1'b0, osc_en = 1'b0;
  logic       low_volt = 1'b0, on_backup = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_n;
  logic [3:0] flags;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  sysmon_supervisor dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .wd_tick(wd_tick), .osc_en(osc_en), .low_volt(low_volt),
    .on_backup(on_backup), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_n(irq_n), .flags(flags)
  );

  typedef struct packed {
    logic [3:0] msk;
    logic [6:0] a_s, a_m, a_h, a_d;
    logic [6:0] c_s, c_m, c_h, c_d;
    logic       hit;
  } avec_t;

  localparam int NV = 9;
  localparam avec_t AV [NV] = '{
    '{4'b0000, 7'd10, 7'd20, 7'd5, 7'd15, 7'd10, 7'd20, 7'd5, 7'd15, 1'b1},
    '{4'b0000, 7'd10, 7'd20, 7'd5, 7'd15, 7'd11, 7'd20, 7'd5, 7'd15, 1'b0},
    '{4'b0000, 7'd10, 7'd20, 7'd5, 7'd15, 7'd10, 7'd21, 7'd5, 7'd15, 1'b0},
    '{4'b0000, 7'd10, 7'd20, 7'd5, 7'd15, 7'd10, 7'd20, 7'd6, 7'd15, 1'b0},
    '{4'b0000, 7'd10, 7'd20, 7'd5, 7'd15, 7'd10, 7'd20, 7'd5, 7'd16, 1'b0},
    '{4'b0001, 7'd30, 7'd20, 7'd5, 7'd15, 7'd10, 7'd20, 7'd5, 7'd15, 1'b1},
    '{4'b1110, 7'd0,  7'd1,  7'd1, 7'd1,  7'd0,  7'd59, 7'd23, 7'd31, 1'b1},
    '{4'b1110, 7'd0,  7'd1,  7'd1, 7'd1,  7'd1,  7'd59, 7'd23, 7'd31, 1'b0},
    '{4'b1111, 7'd3,  7'd3,  7'd3, 7'd3,  7'd44, 7'd12, 7'd9,  7'd2,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic stick(input logic [6:0] s, m, h, d);
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic wdt(input int n);
    for (int k = 0; k < n; k++) begin
      wd_tick = 1'b1;
      @(negedge clk);
    end
    wd_tick = 1'b0;
  endtask

  task automatic clr();
    logic [7:0] dmy;
    rd(3'd6, dmy);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 irq_n", irq_n, 1);
    rd(3'd5, rv); chk("R1 ctrl", rv, 8'h00);
    rd(3'd4, rv); chk("R1 timeout", rv, 8'd10);
    rd(3'd1, rv); chk("R1 match", rv, 8'h00);

    // R12 readback
    wr(3'd0, 8'h85); rd(3'd0, rv); chk("R12 match readback", rv, 8'h85);
    wr(3'd5, 8'hF1); rd(3'd5, rv); chk("R12 ctrl readback", rv, 8'hF0);
    chk("R12 no irq without flags", irq_n, 1);
    wr(3'd5, 8'h00);
    rd(3'd7, rv); chk("R12 unused addr", rv, 8'h00);
    #1 chk("R12 rdata idle", reg_rdata, 8'h00);

    // R2 R3 alarm vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {AV[i].msk[0], AV[i].a_s});
      wr(3'd1, {AV[i].msk[1], AV[i].a_m});
      wr(3'd2, {AV[i].msk[2], AV[i].a_h});
      wr(3'd3, {AV[i].msk[3], AV[i].a_d});
      stick(AV[i].c_s, AV[i].c_m, AV[i].c_h, AV[i].c_d);
      chk($sformatf("R2/R3 alarm vector %0d", i), flags[0], AV[i].hit);
      clr();
    end

    // R4 no tick, no alarm
    wr(3'd0, 8'd10); wr(3'd1, 8'd20); wr(3'd2, 8'd5); wr(3'd3, 8'd15);
    cur_sec = 7'd10; cur_min = 7'd20; cur_hour = 7'd5; cur_date = 7'd15;
    repeat (3) @(negedge clk);
    chk("R4 match without tick", flags[0], 0);
    stick(7'd10, 7'd20, 7'd5, 7'd15);
    chk("R4 match with tick", flags[0], 1);

    // R5 read returns and clears
    rd(3'd6, rv); chk("R5 read value", rv, 8'h01);
    chk("R5 cleared", flags, 0);
    wr(3'd0, 8'h80); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
    reg_rd = 1'b1; reg_addr = 3'd6; sec_tick = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; sec_tick = 1'b0;
    chk("R5 set wins over clear", flags[0], 1);

    // R11 gating of the alarm flag
    chk("R11 disabled flag no irq", irq_n, 1);
    wr(3'd5, 8'h10);
    chk("R11 enable asserts irq", irq_n, 0);
    clr();
    chk("R11 irq released after read", irq_n, 1);

    // R6 watchdog period from WD_INIT
    wr(3'd5, 8'h30);
    osc_en = 1'b1;
    wdt(9);  chk("R6 before expiry", flags[1], 0);
    wdt(1);  chk("R6 expiry at tick 10", flags[1], 1);
    chk("R11 wdog irq", irq_n, 0);
    clr();

    // R8 timeout write alone keeps period
    wr(3'd4, 8'd4);
    wdt(4);  chk("R8 old period still running", flags[1], 0);
    wdt(5);  chk("R8 tick 9", flags[1], 0);
    wdt(1);  chk("R8 old period expiry", flags[1], 1);
    clr();

    // R7 kick loads the stored timeout
    wr(3'd5, 8'h31);
    wdt(3);  chk("R7 new period tick 3", flags[1], 0);
    wdt(1);  chk("R7 new period expiry", flags[1], 1);
    clr();
    wdt(3);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h31; wd_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; wd_tick = 1'b0;
    chk("R7 kick on expiring tick silent", flags[1], 0);
    wdt(3);  chk("R7 restart after kick", flags[1], 0);
    wdt(1);  chk("R7 expiry after kick", flags[1], 1);
    clr();

    // R9 oscillator off freezes, zero disables
    osc_en = 1'b0;
    wdt(10); chk("R9 frozen", flags[1], 0);
    osc_en = 1'b1;
    wdt(3);  chk("R9 resumed tick 3", flags[1], 0);
    wdt(1);  chk("R9 resumed expiry", flags[1], 1);
    clr();
    wr(3'd4, 8'd0); wr(3'd5, 8'h31);
    wdt(20); chk("R9 zero timeout disabled", flags[1], 0);
    rd(3'd4, rv); chk("R12 timeout readback", rv, 8'h00);

    // R10 supply events
    wr(3'd5, 8'hC0);
    low_volt = 1'b1; @(negedge clk);
    chk("R10 low voltage flag", flags[2], 1);
    chk("R11 low voltage irq", irq_n, 0);
    clr();
    repeat (2) @(negedge clk);
    chk("R10 level does not reset flag", flags[2], 0);
    low_volt = 1'b0;
    on_backup = 1'b1; @(negedge clk);
    chk("R10 backup flag", flags[3], 1);
    rd(3'd6, rv); chk("R10 backup read", rv, 8'h08);
    @(negedge clk);
    chk("R10 irq released", irq_n, 1);

    summary();
  end
endmodule